// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers up to three banks of 32 level-sensitive interrupt lines and presents them to a processor as two request outputs, a normal request and a fast request. A per-source mask bit keeps a line away from both outputs. A per-source select bit moves an unmasked line onto the fast output as well. For the lowest-numbered active line the block works out a vector value, so that the interrupt handler can index a jump table with it directly.

Software reaches the controller through a single-cycle register strobe over a 0x400-byte window. The registers sit at these word offsets: vector 0x00, base 0x04, protect 0x08, NMI control 0x0C. Each per-bank group has three words, one per bank, at +0, +4 and +8 from its group base: pending 0x10, fast-pending 0x20, select 0x30, enable 0x40, mask 0x50. Inside a group, address bits [3:2] give the bank. Base, protect, NMI control and enable are only stored. None of them gates anything.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The pending bit of each source takes the level of its input at every clock edge. It is not latched. A pending read returns the sampled levels, with source n at bank n/32, bit n%32.
- R2: `irq_o` is high one cycle after an edge whenever some pending bit is set and its mask bit (1 = masked) is clear. Otherwise `irq_o` is low.
- R3: `fiq_o` is high when some pending, unmasked source also has its select bit set (1 = fast).
- R4: A read of the vector at 0x00 returns (bank*32+bit)*4 for the lowest-numbered source that is pending and unmasked. It returns 0 when there is no such source.
- R5: Writes to the pending words (0x10, 0x14, 0x18) have no effect.
- R6: A fast-pending bit is set in the cycle after its source drives `fiq_o`, and it stays set after the source falls. A write to a fast-pending word clears the bits where the written data is 1 and leaves the others unchanged.
- R7: A write to base (0x04) stores the data with bits [1:0] forced to 0. Protect, NMI, select, enable and mask read back exactly what was written.
- R8: The enable words store data but do not affect `irq_o`, `fiq_o` or the vector.
- R9: In the per-bank groups, address bits [3:2] select the bank. Offset +0xC, and any bank index at or above the configured bank count, reads 0 and ignores writes.
- R10: Reset clears every register, so all reads return 0 and both outputs are low.
- R11: Reads from unmapped offsets (0x60 and above, or not word-aligned) return 0. Writes to those offsets and to the vector register change nothing.
- R12: Read data appears on `bus_rdata_o` in the cycle after the read strobe. It holds until the next read, and writes do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt source lines |
| bus_sel_i | input | 1 | Single-cycle access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read, qualified by the strobe |
| bus_addr_i | input | ADDR_W | Byte offset in the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The vector is tested with several source combinations. One pattern drives a single low source. Another drives sources in two different banks, to show that the lowest index wins. Masking the current winner shows that the next source takes over. A source in the top bank and bit 31 of bank 0 check the edges of the bank-times-32 arithmetic. The select and mask patterns separate the fast path from the normal one, and a toggled enable word shows that enable gates nothing. Address patterns at +0xC, at unmapped offsets and with pending writes show that writes are ignored, because each of these reads back unchanged afterwards.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int BANK_W = 32;
    localparam int MAX_BANKS = 3;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_PEND,
        FLD_FPEND,
        FLD_SEL,
        FLD_EN,
        FLD_MASK
    } fld_e;

    typedef struct packed {
        logic [BANK_W-1:0] pend;
        logic [BANK_W-1:0] fpend;
        logic [BANK_W-1:0] sel;
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] mask;
    } bank_regs_t;

    typedef struct packed {
        logic [BANK_W-1:0] base;
        logic [BANK_W-1:0] protect;
        logic [BANK_W-1:0] nmi;
        logic [BANK_W-1:0] rdata;
    } top_regs_t;

    // group index is bus_addr[ADDR_W-1:4]
    localparam int GRP_SCALAR = 0;
    localparam int GRP_PEND   = 1;
    localparam int GRP_FPEND  = 2;
    localparam int GRP_SEL    = 3;
    localparam int GRP_EN     = 4;
    localparam int GRP_MASK   = 5;
endpackage

// File: rtl/vic_bank.sv
module vic_bank
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src_i,
    input  logic              wr_i,
    input  fld_e              fld_i,
    input  logic [BANK_W-1:0] wdata_i,
    output bank_regs_t        regs_o,
    output logic [BANK_W-1:0] act_o,
    output logic              fast_o
);
    bank_regs_t regs_d, regs_q;
    logic [BANK_W-1:0] clr_mask;

    always_comb begin
        regs_d      = regs_q;
        regs_d.pend = src_i;
        clr_mask    = '0;
        if (wr_i) begin
            case (fld_i)
                FLD_SEL:   regs_d.sel  = wdata_i;
                FLD_EN:    regs_d.en   = wdata_i;
                FLD_MASK:  regs_d.mask = wdata_i;
                FLD_FPEND: clr_mask    = wdata_i;
                default:   ;
            endcase
        end
        // sticky record of fast-routed sources; setting wins over clearing
        regs_d.fpend = (regs_q.fpend & ~clr_mask)
                     | (regs_q.pend & ~regs_q.mask & regs_q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
    assign act_o  = regs_q.pend & ~regs_q.mask;
    assign fast_o = |(act_o & regs_q.sel);
endmodule

// File: rtl/vic_vector.sv
module vic_vector
    import vic_pkg::*;
#(
    parameter int NUM_BANK = 3
) (
    input  logic [NUM_BANK-1:0][BANK_W-1:0] act_i,
    output logic [BANK_W-1:0]               vec_o
);
    // descending scan: the last hit written is the lowest-numbered source
    always_comb begin
        vec_o = '0;
        for (int b = NUM_BANK - 1; b >= 0; b--) begin
            for (int i = BANK_W - 1; i >= 0; i--) begin
                if (act_i[b][i]) vec_o = BANK_W'((b * BANK_W + i) * 4);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BANK_W-1:0]  bus_wdata_i,
    output logic [BANK_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int NUM_BANK = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int PAD_W    = NUM_BANK * BANK_W;
    localparam int GRP_W    = ADDR_W - 4;

    logic [PAD_W-1:0]                 src_pad;
    logic [NUM_BANK-1:0][BANK_W-1:0]  act;
    logic [NUM_BANK-1:0]              fast;
    logic [NUM_BANK-1:0]              bank_wr;
    bank_regs_t                       bregs [NUM_BANK];
    logic [BANK_W-1:0]                vec;
    fld_e                             fld;
    logic [GRP_W-1:0]                 grp;
    logic [1:0]                       bidx;
    logic                             aligned, bank_ok;
    top_regs_t                        st_d, st_q;
    logic [BANK_W-1:0]                rd_val;

    always_comb begin
        src_pad              = '0;
        src_pad[NUM_SRC-1:0] = src_i;
    end

    assign grp     = bus_addr_i[ADDR_W-1:4];
    assign bidx    = bus_addr_i[3:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign bank_ok = (int'(bidx) < NUM_BANK);

    always_comb begin
        case (int'(grp))
            GRP_PEND:  fld = FLD_PEND;
            GRP_FPEND: fld = FLD_FPEND;
            GRP_SEL:   fld = FLD_SEL;
            GRP_EN:    fld = FLD_EN;
            GRP_MASK:  fld = FLD_MASK;
            default:   fld = FLD_NONE;
        endcase
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        assign bank_wr[b] = bus_sel_i && bus_wr_i && aligned && bank_ok
                         && (bidx == 2'(b));
        vic_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_pad[b*BANK_W +: BANK_W]),
            .wr_i    (bank_wr[b]),
            .fld_i   (fld),
            .wdata_i (bus_wdata_i),
            .regs_o  (bregs[b]),
            .act_o   (act[b]),
            .fast_o  (fast[b])
        );
    end

    vic_vector #(.NUM_BANK(NUM_BANK)) u_vec (
        .act_i (act),
        .vec_o (vec)
    );

    always_comb begin
        rd_val = '0;
        if (aligned) begin
            if (int'(grp) == GRP_SCALAR) begin
                case (bidx)
                    2'd0: rd_val = vec;
                    2'd1: rd_val = st_q.base;
                    2'd2: rd_val = st_q.protect;
                    default: rd_val = st_q.nmi;
                endcase
            end else begin
                for (int b = 0; b < NUM_BANK; b++) begin
                    if (bidx == 2'(b)) begin
                        case (fld)
                            FLD_PEND:  rd_val = bregs[b].pend;
                            FLD_FPEND: rd_val = bregs[b].fpend;
                            FLD_SEL:   rd_val = bregs[b].sel;
                            FLD_EN:    rd_val = bregs[b].en;
                            FLD_MASK:  rd_val = bregs[b].mask;
                            default:   rd_val = '0;
                        endcase
                    end
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_sel_i && !bus_wr_i) st_d.rdata = rd_val;
        if (bus_sel_i && bus_wr_i && aligned && int'(grp) == GRP_SCALAR) begin
            case (bidx)
                2'd1: st_d.base    = bus_wdata_i & ~BANK_W'(3);
                2'd2: st_d.protect = bus_wdata_i;
                2'd3: st_d.nmi     = bus_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;
    assign irq_o       = |act;
    assign fiq_o       = |fast;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int NUM_SRC = 96,
    parameter int ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bus_sel_i,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [31:0]        bus_rdata_o,
    input logic               irq_o,
    input logic               fiq_o
);
    logic seen_q;
    logic rd_vec, rd_base, rd_unmapped;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign rd_vec      = bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(0);
    assign rd_base     = bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(4);
    assign rd_unmapped = bus_sel_i && !bus_wr_i && bus_addr_i >= ADDR_W'('h60);

    assert_quiet_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(src_i) == '0) |-> !irq_o);

    assert_fiq_needs_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    assert_vec_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_vec && !irq_o) |-> bus_rdata_o == 32'd0);

    assert_vec_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_vec) |-> bus_rdata_o[1:0] == 2'b00);

    assert_base_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_base) |-> bus_rdata_o[1:0] == 2'b00);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_unmapped) |-> bus_rdata_o == 32'd0);
endmodule

bind irq_vector_ctrl vic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    localparam int NSRC = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            sel = 1'b0;
    logic            wr = 1'b0;
    logic [9:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq, fiq;
    int              n_chk = 0;
    int              n_fail = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(NSRC), .ADDR_W(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk); sel = 1'b0; d = rdata;
    endtask

    task automatic wrr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic drive(input logic [NSRC-1:0] v);
        @(negedge clk); src = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk); rst_n = 1'b0; src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 irq", 32'(irq), 0);
        check("R10 fiq", 32'(fiq), 0);
        for (int a = 0; a < 'h60; a += 4) begin
            rd(10'(a), d);
            check($sformatf("R10 reg 0x%0h", a), d, 0);
        end
    endtask

    task automatic t_level;
        logic [31:0] d;
        drive(NSRC'(1) << 33);
        rd(10'h14, d); check("R1 pending bank1", d, 32'h2);
        check("R2 irq on", 32'(irq), 1);
        drive('0);
        rd(10'h14, d); check("R1 pending follows low", d, 0);
        check("R2 irq off", 32'(irq), 0);
    endtask

    task automatic t_vector;
        logic [31:0] d;
        drive((NSRC'(1) << 5) | (NSRC'(1) << 40));
        rd(10'h00, d); check("R4 lowest of two banks", d, 20);
        wrr(10'h50, 32'h20);
        rd(10'h00, d); check("R4 next after mask", d, 160);
        wrr(10'h54, 32'hFFFF_FFFF);
        check("R2 all masked irq", 32'(irq), 0);
        rd(10'h00, d); check("R4 none gives zero", d, 0);
        drive(NSRC'(1) << 70);
        rd(10'h00, d); check("R4 top bank", d, 280);
        check("R2 top bank irq", 32'(irq), 1);
        drive(NSRC'(1) << 31);
        rd(10'h00, d); check("R4 bit 31", d, 124);
        wrr(10'h50, 0); wrr(10'h54, 0); drive('0);
    endtask

    task automatic t_fast;
        logic [31:0] d;
        drive(NSRC'(1) << 3);
        check("R3 not selected", 32'(fiq), 0);
        wrr(10'h30, 32'h8);
        check("R3 selected fiq", 32'(fiq), 1);
        wrr(10'h50, 32'h8);
        check("R3 masked fiq", 32'(fiq), 0);
        check("R2 masked irq", 32'(irq), 0);
        wrr(10'h50, 0);
        drive('0);
        rd(10'h20, d); check("R6 sticky", d, 32'h8);
        wrr(10'h20, 32'h1);
        rd(10'h20, d); check("R6 clear other bit kept", d, 32'h8);
        wrr(10'h20, 32'h8);
        rd(10'h20, d); check("R6 cleared", d, 0);
        wrr(10'h30, 0);
    endtask

    task automatic t_pend_ro;
        logic [31:0] d;
        drive(NSRC'(1) << 64);
        wrr(10'h18, 32'hFFFF_0000);
        rd(10'h18, d); check("R5 pend write ignored", d, 32'h1);
        wrr(10'h10, 32'hFFFF_FFFF);
        rd(10'h10, d); check("R5 pend bank0 unchanged", d, 0);
        drive('0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wrr(10'h04, 32'h1234_567B);
        rd(10'h04, d); check("R7 base low bits", d, 32'h1234_5678);
        wrr(10'h08, 32'hA5A5_0003);
        rd(10'h08, d); check("R7 protect", d, 32'hA5A5_0003);
        wrr(10'h0C, 32'h0000_00FF);
        rd(10'h0C, d); check("R7 nmi", d, 32'hFF);
        wrr(10'h58, 32'hC000_0001);
        rd(10'h58, d); check("R7 mask bank2", d, 32'hC000_0001);
        wrr(10'h58, 0);
        // R12: data held across idle cycles and writes
        rd(10'h04, d);
        wrr(10'h0C, 0);
        repeat (3) @(negedge clk);
        check("R12 rdata held", rdata, 32'h1234_5678);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        drive(NSRC'(1) << 2);
        wrr(10'h30, 32'h4);
        wrr(10'h40, 0);
        check("R8 en0 irq", 32'(irq), 1);
        check("R8 en0 fiq", 32'(fiq), 1);
        wrr(10'h40, 32'hFFFF_FFFF);
        rd(10'h40, d); check("R8 en stored", d, 32'hFFFF_FFFF);
        rd(10'h00, d); check("R8 vector unaffected", d, 8);
        wrr(10'h30, 0); wrr(10'h40, 0); drive('0);
    endtask

    task automatic t_decode;
        logic [31:0] d;
        wrr(10'h38, 32'h0F0F_0F0F);
        rd(10'h38, d); check("R9 bank2 select", d, 32'h0F0F_0F0F);
        rd(10'h30, d); check("R9 bank0 untouched", d, 0);
        wrr(10'h3C, 32'hFFFF_FFFF);
        rd(10'h3C, d); check("R9 plus 0xC reads zero", d, 0);
        rd(10'h38, d); check("R9 plus 0xC write ignored", d, 32'h0F0F_0F0F);
        wrr(10'h38, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wrr(10'h50, 32'h55);
        wrr(10'h100, 32'hFFFF_FFFF);
        wrr(10'h51, 32'hFFFF_FFFF);
        rd(10'h50, d); check("R11 unmapped write no effect", d, 32'h55);
        rd(10'h3FC, d); check("R11 unmapped read", d, 0);
        rd(10'h06, d); check("R11 misaligned read", d, 0);
        wrr(10'h00, 32'hFFFF_FFFF);
        rd(10'h00, d); check("R11 vector write ignored", d, 0);
        wrr(10'h50, 0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_vector();
        t_fast();
        t_pend_ro();
        t_regs();
        t_enable();
        t_decode();
        t_unmapped();
        wrr(10'h50, 32'hFF);
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule